// File: doc/BRIEF.md
# Fabric Error Notifier Aggregator

This block gathers the error-pending flags of a set of error monitors inside an interconnect fabric and combines them into one interrupt line. Software reads a status word with one bit per monitor. To locate the registers of the monitor that raised the flag, software writes a one-hot selector and then reads the 64-bit base address of that monitor as two 32-bit halves. The base addresses come from elaboration parameters: a first base plus a fixed stride per monitor.

The block's own registers are guarded by a write firewall. When the check is switched on, a write is accepted only if the issuing master has its bit set in a permission bitmap. Master 1 is the CPU cluster. A write that fails the check is dropped without a response. A redirect mask bit chooses how an in-band bus fault is reported. With the bit clear, the fault is returned as a synchronous error pulse. With the bit set, the pulse is suppressed and the fault is latched as a sticky flag that raises the interrupt.

The register port is a plain 32-bit bus. A write completes in the cycle it is presented. Read data comes back one cycle after the request, together with a valid pulse.

Top module: `fabric_err_notifier`

## Requirements
- R1: After a synchronous reset, every register reads 0, and `irq` and `sync_err` are 0.
- R2: The interrupt-enable register at offset 0x00 holds one bit per monitor in bits [N_MON-1:0]. Writing 0x1FF enables all nine monitors in the default build. Bits above N_MON read 0.
- R3: The status word at offset 0x40 reads back `mon_pending` in bits [N_MON-1:0], so a bit is 1 while that monitor has an error pending.
- R4: `irq` is registered. One cycle after its inputs, it equals the OR over all monitors of (pending AND enable), ORed with the sticky redirected-fault flag.
- R5: After a one-hot value with bit i set is written to the selector at offset 0x60, offset 0x80 reads the low 32 bits and offset 0x84 reads the high 32 bits of MON_BASE + i*MON_STRIDE.
- R6: When the selector is zero, or has more than one bit set (upper bits included), offsets 0x80 and 0x84 read 0.
- R7: When bit 17 of the firewall control register (offset 0xC0) is 0, a write from any master is accepted.
- R8: When bit 17 is 1, a write is accepted only if bit `bus_master` of the permission register (offset 0xC4) is 1. Otherwise the write is dropped and the target register keeps its old value.
- R9: When bit 0 of the redirect register (offset 0xC8) is 0, a pulse on `inband_fault` produces a one-cycle `sync_err` pulse in the next cycle and does not set the sticky flag.
- R10: When bit 0 of the redirect register is 1, `inband_fault` produces no `sync_err` and sets the sticky flag, which reads as bit 1 at 0xC8 and raises `irq`. Writing 1 to bit 1 clears the flag.
- R11: `bus_rvalid` pulses for one cycle, one cycle after each read request, with the data in `bus_rdata`. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_master | input | MID_W | ID of the requesting master |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid pulse |
| mon_pending | input | N_MON | Error-pending flag from each monitor |
| inband_fault | input | 1 | In-band bus fault event |
| sync_err | output | 1 | Synchronous bus error response pulse |
| irq | output | 1 | Aggregated interrupt, registered |

## Verification
The bench uses the default build: nine monitors, 32 masters, and a base address whose upper word is non-zero. This brings every selector position and both halves of each base address within reach. With 32 masters, a blocked master (ID 7) and a permitted master (ID 1, the CPU cluster) can both be driven against the same bitmap. The nine-bit enable exposes the boundary between implemented and unused bits when 0xFFFFFFFF is written. The redirect mask is exercised in both settings, and the sticky flag is checked through the interrupt and through readback.

// File: rtl/notif_pkg.sv
package notif_pkg;
  localparam logic [7:0] OFS_IRQ_EN  = 8'h00;
  localparam logic [7:0] OFS_PEND    = 8'h40;
  localparam logic [7:0] OFS_SEL     = 8'h60;
  localparam logic [7:0] OFS_ADR_LO  = 8'h80;
  localparam logic [7:0] OFS_ADR_HI  = 8'h84;
  localparam logic [7:0] OFS_FW_CTL  = 8'hC0;
  localparam logic [7:0] OFS_FW_PERM = 8'hC4;
  localparam logic [7:0] OFS_REDIR   = 8'hC8;
  localparam int FW_EN_BIT   = 17;
  localparam int REDIR_MASK  = 0;
  localparam int REDIR_STICK = 1;
  localparam int DW = 32;
endpackage

// File: rtl/notif_fw_gate.sv
module notif_fw_gate #(
  parameter int N_MASTERS = 32,
  parameter int MID_W = 5
) (
  input  logic                 fw_en,
  input  logic [N_MASTERS-1:0] perm,
  input  logic [MID_W-1:0]     master,
  output logic                 wr_ok
);
  logic granted;
  always_comb begin
    granted = 1'b0;
    for (int m = 0; m < N_MASTERS; m++) begin
      if (master == MID_W'(m)) granted = perm[m];
    end
    wr_ok = !fw_en || granted;
  end
endmodule

// File: rtl/notif_base_lookup.sv
module notif_base_lookup #(
  parameter int N_MON = 9,
  parameter logic [63:0] MON_BASE = 64'h0000_0023_0C00_0000,
  parameter logic [63:0] MON_STRIDE = 64'h0000_0000_0001_0000
) (
  input  logic [31:0] sel,
  output logic [63:0] base_addr
);
  logic        single;
  logic [63:0] hit_addr [N_MON];

  assign single = (sel != 32'd0) && ((sel & (sel - 32'd1)) == 32'd0);

  for (genvar g = 0; g < N_MON; g++) begin : g_mon
    localparam logic [63:0] ADDR_G = MON_BASE + MON_STRIDE * 64'(g);
    assign hit_addr[g] = sel[g] ? ADDR_G : 64'd0;
  end

  always_comb begin
    base_addr = 64'd0;
    if (single) begin
      for (int i = 0; i < N_MON; i++) base_addr = base_addr | hit_addr[i];
    end
  end
endmodule

// File: rtl/notif_irq_combine.sv
module notif_irq_combine #(
  parameter int N_MON = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MON-1:0] pend,
  input  logic [N_MON-1:0] en,
  input  logic             extra,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (|(pend & en)) | extra;
  end
endmodule

// File: rtl/fabric_err_notifier.sv
module fabric_err_notifier
  import notif_pkg::*;
#(
  parameter int N_MON = 9,
  parameter int N_MASTERS = 32,
  parameter int ADDR_W = 8,
  parameter logic [63:0] MON_BASE = 64'h0000_0023_0C00_0000,
  parameter logic [63:0] MON_STRIDE = 64'h0000_0000_0001_0000,
  localparam int MID_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [MID_W-1:0]  bus_master,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [N_MON-1:0]  mon_pending,
  input  logic              inband_fault,
  output logic              sync_err,
  output logic              irq
);
  logic [N_MON-1:0]     en_q;
  logic [31:0]          sel_q;
  logic                 fw_en_q;
  logic [N_MASTERS-1:0] perm_q;
  logic                 redir_mask_q;
  logic                 sticky_q;

  logic        wr_ok;
  logic        wr_acc;
  logic [63:0] sel_base;
  logic [31:0] rd_mux;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  notif_fw_gate #(.N_MASTERS(N_MASTERS), .MID_W(MID_W)) fw_i (
    .fw_en (fw_en_q),
    .perm  (perm_q),
    .master(bus_master),
    .wr_ok (wr_ok)
  );

  notif_base_lookup #(.N_MON(N_MON), .MON_BASE(MON_BASE), .MON_STRIDE(MON_STRIDE)) lk_i (
    .sel      (sel_q),
    .base_addr(sel_base)
  );

  notif_irq_combine #(.N_MON(N_MON)) ic_i (
    .clk  (clk),
    .rst  (rst),
    .pend (mon_pending),
    .en   (en_q),
    .extra(sticky_q),
    .irq  (irq)
  );

  assign wr_acc = bus_valid && bus_write && wr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q         <= '0;
      sel_q        <= '0;
      fw_en_q      <= 1'b0;
      perm_q       <= '0;
      redir_mask_q <= 1'b0;
    end else if (wr_acc) begin
      if (hit(bus_addr, OFS_IRQ_EN))  en_q    <= bus_wdata[N_MON-1:0];
      if (hit(bus_addr, OFS_SEL))     sel_q   <= bus_wdata;
      if (hit(bus_addr, OFS_FW_CTL))  fw_en_q <= bus_wdata[FW_EN_BIT];
      if (hit(bus_addr, OFS_FW_PERM)) perm_q  <= bus_wdata[N_MASTERS-1:0];
      if (hit(bus_addr, OFS_REDIR))   redir_mask_q <= bus_wdata[REDIR_MASK];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      sync_err <= inband_fault && !redir_mask_q;
      if (inband_fault && redir_mask_q)
        sticky_q <= 1'b1;
      else if (wr_acc && hit(bus_addr, OFS_REDIR) && bus_wdata[REDIR_STICK])
        sticky_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = 32'd0;
    if (hit(bus_addr, OFS_IRQ_EN))  rd_mux[N_MON-1:0] = en_q;
    if (hit(bus_addr, OFS_PEND))    rd_mux[N_MON-1:0] = mon_pending;
    if (hit(bus_addr, OFS_SEL))     rd_mux = sel_q;
    if (hit(bus_addr, OFS_ADR_LO))  rd_mux = sel_base[31:0];
    if (hit(bus_addr, OFS_ADR_HI))  rd_mux = sel_base[63:32];
    if (hit(bus_addr, OFS_FW_CTL))  rd_mux[FW_EN_BIT] = fw_en_q;
    if (hit(bus_addr, OFS_FW_PERM)) rd_mux[N_MASTERS-1:0] = perm_q;
    if (hit(bus_addr, OFS_REDIR)) begin
      rd_mux[REDIR_MASK]  = redir_mask_q;
      rd_mux[REDIR_STICK] = sticky_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= 32'd0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/notif_chk.sv
module notif_chk
  import notif_pkg::*;
#(
  parameter int N_MON = 9,
  parameter int N_MASTERS = 32,
  parameter int ADDR_W = 8,
  parameter int MID_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [MID_W-1:0]  bus_master,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic [N_MON-1:0]  mon_pending,
  input logic              inband_fault,
  input logic              sync_err,
  input logic              irq,
  input logic [N_MON-1:0]  en_q,
  input logic [31:0]       sel_q,
  input logic              fw_en_q,
  input logic [N_MASTERS-1:0] perm_q,
  input logic              redir_mask_q
);
  logic sel_single;
  logic blocked_en_wr;
  assign sel_single = $onehot(sel_q);
  assign blocked_en_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_IRQ_EN))
                         && fw_en_q && !perm_q[bus_master];

  AST_IRQ_ON_PENDING: assert property (@(posedge clk) disable iff (rst)
    (|(mon_pending & en_q)) |=> irq); // R4
  AST_BLOCKED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    blocked_en_wr |=> $stable(en_q)); // R8
  AST_SYNC_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    sync_err |-> $past(inband_fault && !redir_mask_q)); // R9
  AST_MASKED_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
    (inband_fault && redir_mask_q) |=> !sync_err); // R10
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_valid && !bus_write)); // R11
  AST_BAD_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr == ADDR_W'(OFS_ADR_LO) && !sel_single)) |-> bus_rdata == 32'd0); // R6
endmodule

bind fabric_err_notifier notif_chk #(
  .N_MON(N_MON), .N_MASTERS(N_MASTERS), .ADDR_W(ADDR_W), .MID_W(MID_W)
) chk_i (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_master(bus_master), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .mon_pending(mon_pending), .inband_fault(inband_fault),
  .sync_err(sync_err), .irq(irq), .en_q(en_q), .sel_q(sel_q), .fw_en_q(fw_en_q),
  .perm_q(perm_q), .redir_mask_q(redir_mask_q)
);

// File: tb/fabric_err_notifier_tb_top.sv
module fabric_err_notifier_tb_top;
  localparam int N_MON = 9;
  localparam int N_MASTERS = 32;
  localparam int ADDR_W = 8;
  localparam int MID_W = 5;
  localparam logic [63:0] BASE = 64'h0000_0023_0C00_0000;
  localparam logic [63:0] STRIDE = 64'h0000_0000_0001_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [MID_W-1:0] bus_master = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [N_MON-1:0] mon_pending = '0;
  logic inband_fault = 1'b0;
  logic sync_err, irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  fabric_err_notifier #(.N_MON(N_MON), .N_MASTERS(N_MASTERS), .ADDR_W(ADDR_W),
    .MON_BASE(BASE), .MON_STRIDE(STRIDE)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_master(bus_master),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .mon_pending(mon_pending),
    .inband_fault(inband_fault), .sync_err(sync_err), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [MID_W-1:0] m);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_master = m;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
  endtask

  // monitor: pops expected read data as the design returns it (R11)
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) check("R11 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 irq after reset", {31'd0, irq}, 0);
    check("R1 sync_err after reset", {31'd0, sync_err}, 0);
    rd(8'h00, 0, "R1 enable reset");
    rd(8'h60, 0, "R1 selector reset");
    rd(8'hC0, 0, "R1 fw ctl reset");
    rd(8'hC4, 0, "R1 perm reset");
    rd(8'hC8, 0, "R1 redirect reset");
    rd(8'h80, 0, "R6 zero selector low");

    // R2 enable register
    wr(8'h00, 32'h1FF, 0);
    rd(8'h00, 32'h1FF, "R2 enable all");
    wr(8'h00, 32'hFFFF_FFFF, 0);
    rd(8'h00, 32'h1FF, "R2 upper bits read zero");

    // R3 status word
    mon_pending = 9'h0A5;
    rd(8'h40, 32'h0A5, "R3 status pattern a");
    mon_pending = 9'h15A;
    rd(8'h40, 32'h15A, "R3 status pattern b");

    // R4 interrupt combine
    repeat (2) @(negedge clk);
    check("R4 irq enabled pending", {31'd0, irq}, 1);
    wr(8'h00, 0, 0);
    repeat (2) @(negedge clk);
    check("R4 irq all disabled", {31'd0, irq}, 0);
    wr(8'h00, 32'h008, 0);
    mon_pending = 9'h008;
    repeat (2) @(negedge clk);
    check("R4 irq single match", {31'd0, irq}, 1);
    mon_pending = 9'h001;
    repeat (2) @(negedge clk);
    check("R4 irq mismatched bit", {31'd0, irq}, 0);
    mon_pending = 0;

    // R5 base lookup per monitor
    for (int i = 0; i < N_MON; i++) begin
      logic [63:0] b;
      b = BASE + STRIDE * 64'(i);
      wr(8'h60, 32'd1 << i, 0);
      rd(8'h80, b[31:0], "R5 base low");
      rd(8'h84, b[63:32], "R5 base high");
    end
    // R6 invalid selectors
    wr(8'h60, 32'h3, 0);
    rd(8'h80, 0, "R6 two bits low");
    rd(8'h84, 0, "R6 two bits high");
    wr(8'h60, 32'h8000_0001, 0);
    rd(8'h84, 0, "R6 upper bit extra");
    wr(8'h60, 0, 0);
    rd(8'h84, 0, "R6 zero selector high");
    rd(8'h10, 0, "R11 unmapped reads zero");

    // R7 firewall off: any master
    wr(8'h00, 32'h0F0, 7);
    rd(8'h00, 32'h0F0, "R7 write from master 7");
    wr(8'hC4, 32'h2, 7);
    wr(8'hC0, 32'h0002_0000, 7);
    rd(8'hC0, 32'h0002_0000, "R7 fw enable written");
    // R8 firewall on
    wr(8'h00, 32'h055, 7);
    rd(8'h00, 32'h0F0, "R8 blocked write dropped");
    wr(8'h00, 32'h055, 1);
    rd(8'h00, 32'h055, "R8 permitted master 1");
    wr(8'hC0, 0, 7);
    rd(8'hC0, 32'h0002_0000, "R8 blocked fw ctl write");
    wr(8'hC0, 0, 1);
    wr(8'h00, 32'h000, 7);
    rd(8'h00, 0, "R7 firewall off again");

    // R9 redirect mask clear
    @(negedge clk); inband_fault = 1;
    @(negedge clk); inband_fault = 0;
    check("R9 sync_err pulse", {31'd0, sync_err}, 1);
    @(negedge clk);
    check("R9 sync_err one cycle", {31'd0, sync_err}, 0);
    check("R9 no irq", {31'd0, irq}, 0);
    rd(8'hC8, 0, "R9 no sticky");

    // R10 redirect mask set
    wr(8'hC8, 32'h1, 0);
    @(negedge clk); inband_fault = 1;
    @(negedge clk); inband_fault = 0;
    check("R10 no sync_err", {31'd0, sync_err}, 0);
    @(negedge clk);
    check("R10 irq raised", {31'd0, irq}, 1);
    rd(8'hC8, 32'h3, "R10 sticky set");
    wr(8'hC8, 32'h3, 0);
    rd(8'hC8, 32'h1, "R10 sticky cleared");
    @(negedge clk);
    check("R10 irq cleared", {31'd0, irq}, 0);

    repeat (3) @(negedge clk);
    check("R11 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule